// File: doc/BRIEF.md
# Serial-Loaded Converter Input Register

This block is the digital front end of a 14-bit voltage-output converter. A host sends 16-bit words over a framed serial link made of an active-low select, a serial clock and a data line. All four serial inputs, including an active-low load strobe, are oversampled by a fast system clock. Each is passed through a two-flop synchronizer, and its edges are found in the system clock domain. The system clock must run at least four times faster than the serial clock.

A word is sent most significant bit first. Its 14 data bits come first, followed by two trailing sub-bits that should be zero. Bits are taken on serial-clock rising edges while select is low. The register is double-buffered: a shift register collects the word, and a separate latch drives the converter code. When the load strobe is held low during a frame, the latch takes the word as select rises. When the strobe is held high, the word is staged, and a later falling edge of the strobe commits it. A frame of any length other than 16 bits is rejected and leaves the latch untouched. In bipolar use the code is read as offset binary, so code 8192 is mid-scale.

Top module: `dac_serial_frontend`

## Requirements
- R1: While select is low, each serial-clock rising edge shifts in one data bit, most significant bit first. Bits 15..2 of the received word are the 14-bit code, and bits 1..0 are the sub-bits.
- R2: Only a frame of exactly 16 serial-clock rising edges between the falling and the rising edge of select is accepted.
- R3: With the load strobe low when select rises, an accepted frame writes its 14-bit code to `dac_code`. The new value is visible no later than four system clocks after the select rise reaches the input pins.
- R4: A frame with any other bit count (0 to 15, or 17 and more) produces a one-cycle pulse on `frame_err` and leaves `dac_code` unchanged. The next correct frame is then accepted normally.
- R5: With the load strobe high when select rises, an accepted frame leaves `dac_code` unchanged and sets `update_pending`. A later falling edge of the strobe, taken while select is high, copies the staged code to `dac_code` and clears `update_pending`.
- R6: A strobe falling edge while `update_pending` is low has no effect on `dac_code`.
- R7: A second accepted frame in four-wire mode, received before the strobe falls, replaces the staged code. The strobe edge then commits only the newest code.
- R8: Reset clears `dac_code` to 0 and `update_pending` to 0, whatever state the block is in.
- R9: Non-zero sub-bits in an accepted frame do not change the committed code. They raise a one-cycle pulse on `subbit_warn`, which never coincides with a `frame_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the latch |
| cs_n_in | input | 1 | Active-low frame select, asynchronous |
| sclk_in | input | 1 | Serial clock, asynchronous; data taken on rising edges |
| din_in | input | 1 | Serial data, MSB first |
| ldac_n_in | input | 1 | Active-low load strobe; low = three-wire commit, falling edge = four-wire commit |
| dac_code | output | 14 | Latched converter code (offset binary in bipolar use) |
| frame_err | output | 1 | One-cycle pulse for a frame of wrong length |
| subbit_warn | output | 1 | One-cycle pulse for an accepted frame with non-zero sub-bits |
| update_pending | output | 1 | A staged code is waiting for the load strobe |

## Verification
Each serial input passes two synchronizer flops and one edge register before the latch register updates. A select or strobe edge driven on the pins therefore shows on `dac_code`, `update_pending` and the pulse outputs three system clocks later. The bench waits eight clocks after every select rise or strobe fall before it compares the outputs. This leaves margin over the three-clock latency without reaching the next stimulus. The single-cycle pulses are counted by a monitor that samples on the falling clock edge, and each test compares the change in those counts against the number of pulses it expects.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int DEF_DATA_W  = 14;
    localparam int DEF_SUB_W   = 2;
    localparam int DEF_STAGES  = 2;

    // which event commits the latch in a given cycle
    typedef enum logic [1:0] {
        COMMIT_NONE  = 2'd0,
        COMMIT_FRAME = 2'd1,
        COMMIT_LOAD  = 2'd2
    } commit_src_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_low,
    input  logic               cs_fall,
    input  logic               sclk_rise,
    input  logic               din,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.cnt = '0;
        end else if (sclk_rise && cs_low) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], din};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word    = st_q.sh;
    assign bit_cnt = st_q.cnt;

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX); // R2
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> st_q.cnt == '0); // R2
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend #(
    parameter int DATA_W = dacfe_pkg::DEF_DATA_W,
    parameter int SUB_W  = dacfe_pkg::DEF_SUB_W,
    parameter int STAGES = dacfe_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              sclk_in,
    input  logic              din_in,
    input  logic              ldac_n_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              frame_err,
    output logic              subbit_warn,
    output logic              update_pending
);
    import dacfe_pkg::*;

    localparam int FRAME_W = DATA_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    // bit order of the synchronized bundle: {load, data, sclk, select}
    localparam int IX_CS   = 0;
    localparam int IX_SCK  = 1;
    localparam int IX_DIN  = 2;
    localparam int IX_LD   = 3;

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic [DATA_W-1:0] staged;
        logic              pending;
        logic              ferr;
        logic              warn;
        logic              cs_prev;
        logic              sck_prev;
        logic              ld_prev;
    } fe_state_t;

    fe_state_t st_d, st_q;

    logic [3:0]         pins_s;
    logic               cs_rise, cs_fall, sck_rise, ld_fall;
    logic [FRAME_W-1:0] rx_word;
    logic [CNT_W-1:0]   rx_cnt;
    logic [DATA_W-1:0]  rx_data;
    logic [SUB_W-1:0]   rx_sub;
    commit_src_e        commit;

    dacfe_sync #(.WIDTH(4), .STAGES(STAGES), .RST_VAL(4'b1001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({ldac_n_in, din_in, sclk_in, cs_n_in}),
        .sync_out(pins_s)
    );

    assign cs_rise  =  pins_s[IX_CS]  && !st_q.cs_prev;
    assign cs_fall  = !pins_s[IX_CS]  &&  st_q.cs_prev;
    assign sck_rise =  pins_s[IX_SCK] && !st_q.sck_prev;
    assign ld_fall  = !pins_s[IX_LD]  &&  st_q.ld_prev;

    dacfe_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (!pins_s[IX_CS]),
        .cs_fall  (cs_fall),
        .sclk_rise(sck_rise),
        .din      (pins_s[IX_DIN]),
        .word     (rx_word),
        .bit_cnt  (rx_cnt)
    );

    assign rx_data = rx_word[FRAME_W-1:SUB_W];
    assign rx_sub  = rx_word[SUB_W-1:0];

    always_comb begin
        st_d          = st_q;
        st_d.ferr     = 1'b0;
        st_d.warn     = 1'b0;
        st_d.cs_prev  = pins_s[IX_CS];
        st_d.sck_prev = pins_s[IX_SCK];
        st_d.ld_prev  = pins_s[IX_LD];
        commit        = COMMIT_NONE;
        if (cs_rise) begin
            if (rx_cnt == CNT_W'(FRAME_W)) begin
                st_d.warn = (rx_sub != '0);
                if (!pins_s[IX_LD]) begin
                    commit       = COMMIT_FRAME;
                    st_d.pending = 1'b0;
                end else begin
                    st_d.staged  = rx_data;
                    st_d.pending = 1'b1;
                end
            end else begin
                st_d.ferr = 1'b1;
            end
        end else if (ld_fall && st_q.pending && pins_s[IX_CS]) begin
            commit       = COMMIT_LOAD;
            st_d.pending = 1'b0;
        end
        case (commit)
            COMMIT_FRAME: st_d.code = rx_data;
            COMMIT_LOAD:  st_d.code = st_q.staged;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cs_prev  <= 1'b1;
            st_q.ld_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code       = st_q.code;
    assign frame_err      = st_q.ferr;
    assign subbit_warn    = st_q.warn;
    assign update_pending = st_q.pending;

    AST_ERR_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> dac_code == $past(dac_code)); // R4
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R4
    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (update_pending && $past(update_pending)) |-> $stable(dac_code)); // R5
    AST_NO_ERR_AND_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && subbit_warn)); // R9
    AST_ERR_NO_PENDING_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !$past(update_pending)) |-> !update_pending); // R2
endmodule

// File: tb/dac_serial_frontend_test.sv
module dac_serial_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b0;
    logic [13:0] dac_code;
    logic        frame_err, subbit_warn, update_pending;

    int errors = 0, checks = 0, ferr_seen = 0, warn_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_frontend uut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk),
        .din_in(din), .ldac_n_in(ldac_n), .dac_code(dac_code),
        .frame_err(frame_err), .subbit_warn(subbit_warn),
        .update_pending(update_pending)
    );

    always @(negedge clk) if (rst_n) begin
        if (frame_err)   ferr_seen++;
        if (subbit_warn) warn_seen++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input int nbits);
        tick(1);
        cs_n = 1'b0; tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            din = (i < 16) ? w[15-i] : 1'b0;
            sclk = 1'b0; tick(HALF);
            sclk = 1'b1; tick(HALF);
        end
        sclk = 1'b0; tick(HALF);
        cs_n = 1'b1; tick(8);
    endtask

    task automatic strobe();
        ldac_n = 1'b0; tick(8);
    endtask

    initial begin
        int base_err, base_warn;
        logic [15:0] lfsr;
        logic [13:0] keep;
        tick(5);
        chk("R8 reset code", dac_code, 0);
        chk("R8 reset pending", update_pending, 0);
        rst_n = 1'b1; tick(4);

        // three-wire mode: walking ones, corners, pseudo-random codes
        ldac_n = 1'b0;
        base_err = ferr_seen;
        for (int b = 0; b < 14; b++) begin
            send({14'(1 << b), 2'b00}, 16);
            chk("R1 R3 walking one", dac_code, 1 << b);
        end
        send({14'h0000, 2'b00}, 16); chk("R3 zero", dac_code, 0);
        send({14'h3FFF, 2'b00}, 16); chk("R3 full", dac_code, 16383);
        send({14'h2000, 2'b00}, 16); chk("R3 midpoint", dac_code, 8192);
        send({14'h1FFF, 2'b00}, 16); chk("R3 below mid", dac_code, 8191);
        lfsr = 16'hACE1;
        for (int k = 0; k < 24; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send({lfsr[13:0], 2'b00}, 16);
            chk("R1 R3 random code", dac_code, int'(lfsr[13:0]));
        end
        chk("R2 no error on good frames", ferr_seen - base_err, 0);

        // wrong lengths
        send({14'h1234, 2'b00}, 16);
        for (int n = 0; n < 20; n++) begin
            if (n == 16) continue;
            base_err = ferr_seen;
            send({14'h2AAA, 2'b00}, n);
            chk("R4 code kept on bad length", dac_code, 14'h1234);
            chk("R4 R2 one error pulse", ferr_seen - base_err, 1);
        end
        send({14'h0F0F, 2'b00}, 16);
        chk("R4 recovery after error", dac_code, 14'h0F0F);

        // sub-bits
        base_warn = warn_seen;
        send({14'h0555, 2'b10}, 16);
        chk("R9 sub-bits ignored", dac_code, 14'h0555);
        chk("R9 warn pulse", warn_seen - base_warn, 1);
        send({14'h0556, 2'b01}, 16);
        chk("R9 warn pulse s0", warn_seen - base_warn, 2);
        send({14'h0557, 2'b00}, 16);
        chk("R9 no warn for zero sub-bits", warn_seen - base_warn, 2);

        // four-wire mode
        keep = dac_code;
        ldac_n = 1'b1; tick(8);
        chk("R6 strobe rise no effect", dac_code, int'(keep));
        send({14'h3210, 2'b00}, 16);
        chk("R5 code held while staged", dac_code, int'(keep));
        chk("R5 pending set", update_pending, 1);
        send({14'h0123, 2'b00}, 16);
        chk("R7 still held", dac_code, int'(keep));
        strobe();
        chk("R7 newest staged committed", dac_code, 14'h0123);
        chk("R5 pending cleared", update_pending, 0);
        ldac_n = 1'b1; tick(8);
        strobe();
        chk("R6 strobe without pending", dac_code, 14'h0123);
        ldac_n = 1'b1; tick(8);
        base_err = ferr_seen;
        send({14'h3333, 2'b00}, 12);
        chk("R4 bad frame not staged", update_pending, 0);
        strobe();
        chk("R4 R6 bad frame not committed", dac_code, 14'h0123);

        // reset while staged
        ldac_n = 1'b1; tick(8);
        send({14'h2222, 2'b00}, 16);
        rst_n = 1'b0; tick(3);
        chk("R8 reset clears code", dac_code, 0);
        chk("R8 reset clears pending", update_pending, 0);
        rst_n = 1'b1; tick(8);
        strobe();
        chk("R8 nothing left after reset", dac_code, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule